// File: doc/BRIEF.md
# Sequential Sum, Divide-by-Eight and Round Unit

This block adds a fixed group of four unsigned 8-bit operands with a single shared adder, one operand per clock, then divides the total by eight and rounds the quotient to the nearest integer. A small control state machine sequences the work. An operand index steps through the captured operands, and the running total, the index and the operands are all held in registers.

A host launches a computation with a valid/ready style handshake. `start` plays the valid role and `ready` the ready role. The transfer happens in a cycle where both are high. All four operands are captured on that edge, so the host holds them for that one cycle only. While the unit works, `ready` stays low and `start` is ignored. That is the unit's only back-pressure, and a host that keeps `start` high simply waits for `ready`. The rounded value appears on `result` on the same edge that `ready` returns high. It then stays there until the next computation finishes.

Top module: `sum_div_round`

## Requirements
- R1: After the asynchronous active-low reset is released, `ready` is 1 and `result` is 0.
- R2: A cycle with `start` and `ready` both high is accepted, and `ready` is 0 in the next cycle.
- R3: After an accepted start, `ready` stays low for exactly 5 cycles and is high again in the 6th cycle after the accepting cycle. A start is therefore accepted 6 cycles after the previous one.
- R4: `result` equals the quotient `S >> 3` of the operand sum S, plus one when the remainder `S & 7` is greater than 3. With S = 11 the result is 1, and with S = 12 it is 2.
- R5: Operand k is taken from bits `[8k+7:8k]` of `opnds`, for k = 0 to 3. Only the values present in the accepting cycle are used, and later changes to `opnds` have no effect on the pending result.
- R6: `start` while `ready` is low has no effect. The busy length and the pending result are unchanged.
- R7: `result` changes only on the edge where `ready` returns high, and it otherwise holds its value across idle time.
- R8: The full-scale sum 1020 (all operands 255) produces 128 with no wrap, and an all-zero operand group produces 0.
- R9: Asserting reset during a computation returns the unit to idle with `ready` 1 and `result` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request (valid side of the handshake) |
| opnds | input | 32 | Four packed operands, operand k at bits [8k+7:8k] |
| ready | output | 1 | High while idle and able to accept a start |
| result | output | 8 | Rounded sum divided by eight |

## Verification
The assertions take for granted that `start` and `opnds` are stable around the rising edge and that reset is the only way to abandon a computation. They do not require the host to hold `start` low while busy. The rounding and width checks assume operands never exceed 8 bits, which the port width enforces. The stimulus drives every input on the falling edge. It deliberately raises `start` and scrambles `opnds` during busy periods, and it pulses reset both while idle and in the middle of a computation.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACCUM = 2'd1,
    ST_FINAL = 2'd2
  } sdr_state_t;
endpackage

// File: rtl/sdr_ctrl.sv
module sdr_ctrl
  import sdr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic last_step,
  output logic ready,
  output logic load_en,
  output logic acc_en,
  output logic fin_en
);
  sdr_state_t st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d    = st_q;
    load_en = 1'b0;
    acc_en  = 1'b0;
    fin_en  = 1'b0;
    ready   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        ready = 1'b1;
        if (start) begin
          load_en = 1'b1;
          st_d    = ST_ACCUM;
        end
      end
      ST_ACCUM: begin
        acc_en = 1'b1;
        // exit on the index value being written, not the one held now
        if (last_step) st_d = ST_FINAL;
      end
      ST_FINAL: begin
        fin_en = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // R3
  accum_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACCUM && last_step) |=> (st_q == ST_FINAL));

  // R3
  final_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FINAL) |=> (st_q == ST_IDLE));

  // R6
  enable_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_en, acc_en, fin_en}));
endmodule

// File: rtl/sdr_round.sv
module sdr_round #(
  parameter int SUM_W = 10,
  parameter int SHIFT = 3,
  parameter int RES_W = SUM_W - SHIFT + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUM_W-1:0] sum_in,
  output logic [RES_W-1:0] rounded
);
  localparam int HALF = 1 << (SHIFT - 1);

  logic [SUM_W-SHIFT-1:0] quot;
  logic [SHIFT-1:0]       rem;
  logic                   bump;

  always_comb begin
    quot    = sum_in[SUM_W-1:SHIFT];
    rem     = sum_in[SHIFT-1:0];
    bump    = (rem > SHIFT'(HALF - 1));
    rounded = RES_W'(quot) + RES_W'(bump);
  end

  // R4: scaled result lies within half a step of the sum, ties rounded up
  rounding_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(rounded) * (1 << SHIFT) - int'(sum_in) <= HALF) &&
     (int'(rounded) * (1 << SHIFT) - int'(sum_in) > -HALF)));
endmodule

// File: rtl/sdr_datapath.sv
module sdr_datapath #(
  parameter int N_OPS = 4,
  parameter int OP_W  = 8,
  parameter int SHIFT = 3,
  parameter int SUM_W = OP_W + $clog2(N_OPS),
  parameter int RES_W = SUM_W - SHIFT + 1,
  parameter int IDX_W = $clog2(N_OPS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_OPS*OP_W-1:0] ops_in,
  input  logic                  load_en,
  input  logic                  acc_en,
  input  logic                  fin_en,
  input  logic [RES_W-1:0]      rnd_val,
  output logic [SUM_W-1:0]      sum_q,
  output logic                  last_step,
  output logic [RES_W-1:0]      result_q
);
  localparam int MAX_SUM = N_OPS * ((1 << OP_W) - 1);

  logic [OP_W-1:0]  op_q [N_OPS];
  logic [IDX_W-1:0] idx_q, idx_nx;
  logic [OP_W-1:0]  op_sel;

  for (genvar k = 0; k < N_OPS; k++) begin : g_op
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       op_q[k] <= '0;
      else if (load_en) op_q[k] <= ops_in[k*OP_W +: OP_W];
    end
  end

  always_comb begin
    op_sel = '0;
    for (int k = 0; k < N_OPS; k++)
      if (idx_q == IDX_W'(k)) op_sel = op_q[k];
  end

  assign idx_nx    = idx_q + IDX_W'(1);
  assign last_step = (idx_nx == IDX_W'(N_OPS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      sum_q <= '0;
    end else if (load_en) begin
      idx_q <= '0;
      sum_q <= '0;
    end else if (acc_en) begin
      idx_q <= idx_nx;
      sum_q <= sum_q + SUM_W'(op_sel);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      result_q <= '0;
    else if (fin_en) result_q <= rnd_val;
  end

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |-> (int'(idx_q) < N_OPS));

  // R8
  sum_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sum_q) <= MAX_SUM);

  // R5
  ops_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !$isunknown(op_q[0])) |=> $stable(op_q[0]));
endmodule

// File: rtl/sum_div_round.sv
module sum_div_round #(
  parameter int N_OPS = 4,
  parameter int OP_W  = 8,
  parameter int SHIFT = 3,
  parameter int SUM_W = OP_W + $clog2(N_OPS),
  parameter int RES_W = SUM_W - SHIFT + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [N_OPS*OP_W-1:0] opnds,
  output logic                  ready,
  output logic [RES_W-1:0]      result
);
  logic             load_en, acc_en, fin_en, last_step;
  logic [SUM_W-1:0] sum_q;
  logic [RES_W-1:0] rnd_val;

  sdr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .last_step (last_step),
    .ready     (ready),
    .load_en   (load_en),
    .acc_en    (acc_en),
    .fin_en    (fin_en)
  );

  sdr_datapath #(
    .N_OPS (N_OPS),
    .OP_W  (OP_W),
    .SHIFT (SHIFT),
    .SUM_W (SUM_W),
    .RES_W (RES_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ops_in    (opnds),
    .load_en   (load_en),
    .acc_en    (acc_en),
    .fin_en    (fin_en),
    .rnd_val   (rnd_val),
    .sum_q     (sum_q),
    .last_step (last_step),
    .result_q  (result)
  );

  sdr_round #(
    .SUM_W (SUM_W),
    .SHIFT (SHIFT),
    .RES_W (RES_W)
  ) u_rnd (
    .clk     (clk),
    .rst_n   (rst_n),
    .sum_in  (sum_q),
    .rounded (rnd_val)
  );

  // busy-length window counted rather than unrolled
  logic [7:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_cnt <= '0;
    else if (ready) busy_cnt <= '0;
    else            busy_cnt <= busy_cnt + 8'd1;
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready);

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (int'(busy_cnt) == N_OPS + 1));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $rose(ready));
endmodule

// File: tb/sim_sum_div_round.sv
module sim_sum_div_round;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] opnds = '0;
  logic        ready;
  logic [7:0]  result;

  always #4 clk = ~clk;

  sum_div_round u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .opnds  (opnds),
    .ready  (ready),
    .result (result)
  );

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";

  // behavioural reference: a countdown and a pending value
  int m_busy = 0;
  int m_ready = 1;
  int m_res = 0;
  int m_pend = 0;

  function automatic int ref_round(input logic [31:0] v);
    int s = 0;
    for (int k = 0; k < 4; k++) s += int'(v[k*8 +: 8]);
    return (s / 8) + (((s % 8) > 3) ? 1 : 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_ready = 1; m_res = 0; m_pend = 0;
    end else if (m_ready == 1) begin
      if (start) begin
        m_pend = ref_round(opnds);
        m_busy = 5;
        m_ready = 0;
      end
    end else begin
      m_busy--;
      if (m_busy == 0) begin
        m_ready = 1;
        m_res = m_pend;
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (int'(ready) != m_ready || int'(result) != m_res) begin
        n_err++;
        $display("FAIL %s ready=%0d result=%0d expected ready=%0d result=%0d",
                 cur_req, ready, result, m_ready, m_res);
      end
    end
  end

  task automatic run_one(input logic [31:0] v, input string req);
    cur_req = req;
    while (!ready) @(negedge clk);
    opnds = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    opnds = 32'hA5A5_A5A5;
    repeat (6) @(negedge clk);
  endtask

  task automatic direct_chk(input int exp, input string req);
    n_chk++;
    if (int'(result) != exp || ready !== 1'b1) begin
      n_err++;
      $display("FAIL %s result=%0d ready=%0d expected result=%0d ready=1",
               req, result, ready, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    direct_chk(0, "R1");

    run_one(32'h0302_0105, "R4");        // sum 11 -> 1
    direct_chk(1, "R4");
    run_one(32'h0302_0106, "R4");        // sum 12 -> 2
    direct_chk(2, "R4");
    run_one(32'hFFFF_FFFF, "R8");        // 1020 -> 128
    direct_chk(128, "R8");
    run_one(32'h0000_0000, "R8");
    direct_chk(0, "R8");
    run_one(32'h0000_00FF, "R5");        // only operand 0: 255 -> 32
    direct_chk(32, "R5");
    run_one(32'h4000_0000, "R5");        // only operand 3: 64 -> 8
    direct_chk(8, "R5");

    // R7: hold through idle time
    cur_req = "R7";
    repeat (10) @(negedge clk);
    direct_chk(8, "R7");

    // R6: start held high and operands scrambled during busy
    cur_req = "R6";
    opnds = 32'h1010_1010;               // sum 64 -> 8
    start = 1'b1;
    @(negedge clk);
    opnds = 32'hFFFF_FFFF;
    repeat (5) @(negedge clk);
    start = 1'b0;
    direct_chk(8, "R6");
    // R2/R3: back-to-back acceptance
    cur_req = "R3";
    opnds = 32'h0808_0808;               // 32 -> 4
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n_chk++;
    if (ready !== 1'b0) begin
      n_err++;
      $display("FAIL R2 ready=%0d expected 0", ready);
    end
    repeat (5) @(negedge clk);
    direct_chk(4, "R3");

    // R9: reset in the middle of a computation
    cur_req = "R9";
    opnds = 32'h7777_7777;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #2;
    n_chk++;
    if (ready !== 1'b1 || result !== 8'd0) begin
      n_err++;
      $display("FAIL R9 ready=%0d result=%0d expected ready=1 result=0", ready, result);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    direct_chk(0, "R9");

    // mixed patterns from a simple LFSR
    begin
      logic [31:0] lf = 32'hACE1_1234;
      for (int i = 0; i < 60; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        run_one(lf, "R4");
        direct_chk(ref_round(lf), "R4");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule